// File: doc/BRIEF.md
# Debug Watch Comparator

This block watches every bus access against four programmable watch slots and records which slots matched. Each slot holds a full watch address, and one shared 32-bit control word holds, for every slot, a pair of enable bits, a two-bit access-type code and a two-bit length code. An access that falls inside an enabled slot's aligned window, with a matching kind, sets that slot's sticky status bit and fires a one-cycle trap pulse.

Software or a debug agent writes the slot addresses and the control word through a small write port (`cfg_sel` 0 to 3 pick an address slot, 4 picks the control word). The control word is visible at all times on `ctrl_word`. A task-switch strobe drops the per-task (local) enables and keeps the persistent (global) ones. A status-clear strobe wipes the status bits. An input `wide_en` allows the 8-byte length code.

The trap pulse comes from a two-state machine. `TRAP_IDLE` is the rest state. The transition IDLE→FIRE is taken on any hit. FIRE→FIRE is taken on a hit in the next access, and FIRE→IDLE is taken when no hit follows. The output `trap` is high exactly while the machine is in `TRAP_FIRE`.

Top module: `watch_unit`

## Requirements
- R1: After reset, `status`, `trap` and `ctrl_word` are all zero.
- R2: A write with `cfg_sel`=4 loads the control word. Bits 15:10 of the control word always read back as zero. `cfg_sel`=0..3 load the address of slot 0..3.
- R3: Slot i is active when control bit 2i (local enable) or bit 2i+1 (global enable) is set. An inactive slot never hits.
- R4: The field of slot i is at control bits 16+4i..19+4i, and its low two bits are the type. The codes are: 00 matches `acc_kind`=0 (fetch), 01 matches `acc_kind`=2 (write), 11 matches `acc_kind`=1 (read) or 2 (write), and 10 never matches. `acc_kind`=3 never matches.
- R5: The high two bits of the field are the length. The codes are: 00 gives 1 byte, 01 gives 2 bytes, 11 gives 4 bytes, and 10 gives 8 bytes. The 8-byte code only works when `wide_en` is 1; otherwise that slot never hits. A hit requires the access address and the slot address to be equal after clearing the low log2(length) bits of both.
- R6: A hit on slot i sets `status[i]` on the next clock edge. Status bits stay set across later accesses until cleared.
- R7: `stat_clr` clears all status bits. A hit in the same cycle still leaves its own bit set.
- R8: `trap` is high for exactly the cycle after each access that hits at least one slot, and low otherwise.
- R9: `task_sw` clears every local-enable bit and leaves the global-enable bits and all other control bits unchanged. If a control write occurs in the same cycle, the written value is stored with its local enables cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Write target: 0..3 slot address, 4 control word |
| cfg_wdata | input | 32 | Write data |
| wide_en | input | 1 | Allows the 8-byte length code |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| task_sw | input | 1 | Task-switch strobe |
| stat_clr | input | 1 | Status-clear strobe |
| ctrl_word | output | 32 | Current control word |
| status | output | 4 | Sticky per-slot hit bits |
| trap | output | 1 | One-cycle hit pulse |

## Verification
Status clearing and hit capture can fall in the same cycle. The bench first leaves slots 0 and 2 set in `status`, then asserts `stat_clr` in the same cycle as a write access that hits only slot 1. It expects `status` to read exactly 0010 afterwards. A task switch and a control-word write can also coincide, and the bench judges that case from `ctrl_word`.

// File: rtl/watch_pkg.sv
package watch_pkg;
    localparam int SLOTS     = 4;
    localparam int CTRL_W    = 32;
    localparam int FIELD_LSB = 16;
    localparam int FIELD_W   = 4;
    localparam logic [CTRL_W-1:0] RSVD_MASK = 32'h0000_FC00;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_NONE  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        TY_EXEC = 2'b00,
        TY_WR   = 2'b01,
        TY_IO   = 2'b10,
        TY_RW   = 2'b11
    } watch_type_e;

    typedef enum logic [1:0] {
        LN_1 = 2'b00,
        LN_2 = 2'b01,
        LN_8 = 2'b10,
        LN_4 = 2'b11
    } watch_len_e;

    typedef enum logic {
        TRAP_IDLE = 1'b0,
        TRAP_FIRE = 1'b1
    } trap_state_e;

    function automatic logic [CTRL_W-1:0] local_en_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int i = 0; i < SLOTS; i++) m[2*i] = 1'b1;
        return m;
    endfunction

    function automatic logic [CTRL_W-1:0] global_en_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int i = 0; i < SLOTS; i++) m[2*i+1] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/watch_slot.sv
module watch_slot
    import watch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]         en_pair,
    input  logic [FIELD_W-1:0] field,
    input  logic [ADDR_W-1:0]  slot_addr,
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [1:0]         acc_kind,
    input  logic               wide_en,
    output logic               hit
);
    logic              type_ok;
    logic              len_ok;
    logic [ADDR_W-1:0] low_mask;
    watch_type_e       ty;
    watch_len_e        ln;

    assign ty = watch_type_e'(field[1:0]);
    assign ln = watch_len_e'(field[3:2]);

    always_comb begin
        unique case (ty)
            TY_EXEC: type_ok = (acc_kind == KIND_FETCH);
            TY_WR:   type_ok = (acc_kind == KIND_WRITE);
            TY_RW:   type_ok = (acc_kind == KIND_READ) || (acc_kind == KIND_WRITE);
            TY_IO:   type_ok = 1'b0;
        endcase
    end

    always_comb begin
        len_ok = 1'b1;
        unique case (ln)
            LN_1: low_mask = '0;
            LN_2: low_mask = ADDR_W'(1);
            LN_4: low_mask = ADDR_W'(3);
            LN_8: begin
                low_mask = ADDR_W'(7);
                len_ok   = wide_en;
            end
        endcase
    end

    assign hit = acc_valid && (|en_pair) && type_ok && len_ok &&
                 ((acc_addr & ~low_mask) == (slot_addr & ~low_mask));
endmodule

// File: rtl/watch_regs.sv
module watch_regs
    import watch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [ADDR_W-1:0]             cfg_wdata,
    input  logic                          task_sw,
    output logic [CTRL_W-1:0]             ctrl_q,
    output logic [SLOTS-1:0][ADDR_W-1:0]  slot_addr_q
);
    localparam logic [CTRL_W-1:0] LOC_MASK = local_en_mask();
    localparam logic [CTRL_W-1:0] GLB_MASK = global_en_mask();

    logic              ctrl_wr;
    logic [CTRL_W-1:0] ctrl_d;

    assign ctrl_wr = cfg_we && (cfg_sel == SEL_W'(SLOTS));

    always_comb begin
        ctrl_d = ctrl_wr ? (CTRL_W'(cfg_wdata) & ~RSVD_MASK) : ctrl_q;
        if (task_sw) ctrl_d = ctrl_d & ~LOC_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_addr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_addr_q[g] <= '0;
            else if (cfg_we && (cfg_sel == SEL_W'(g)))
                slot_addr_q[g] <= cfg_wdata;
        end
    end

    // R2: reserved control bits read zero after a control write
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ((ctrl_q & RSVD_MASK) == '0));

    // R9: task switch drops local enables
    a_r9_local_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        task_sw |=> ((ctrl_q & LOC_MASK) == '0));

    // R9: task switch alone keeps global enables
    a_r9_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (task_sw && !cfg_we) |=> ((ctrl_q & GLB_MASK) == ($past(ctrl_q) & GLB_MASK)));
endmodule

// File: rtl/watch_status.sv
module watch_status
    import watch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] hit_vec,
    input  logic             stat_clr,
    output logic [SLOTS-1:0] status,
    output logic             trap
);
    trap_state_e state_q;
    trap_state_e state_d;
    logic        any_hit;

    assign any_hit = |hit_vec;

    always_comb begin
        unique case (state_q)
            TRAP_IDLE: state_d = any_hit ? TRAP_FIRE : TRAP_IDLE;
            TRAP_FIRE: state_d = any_hit ? TRAP_FIRE : TRAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        trap = (state_q == TRAP_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        status <= '0;
        else if (stat_clr) status <= hit_vec;
        else               status <= status | hit_vec;
    end

    // R6: status bits are sticky without a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr |=> ((status & $past(status)) == $past(status)));

    // R7: a clear with no hit empties the status
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !any_hit) |=> (status == '0));

    // R8: trap implies some status bit is set
    a_r8_trap_status: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (status != '0));
endmodule

// File: rtl/watch_unit.sv
module watch_unit
    import watch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               wide_en,
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [1:0]         acc_kind,
    input  logic               task_sw,
    input  logic               stat_clr,
    output logic [CTRL_W-1:0]  ctrl_word,
    output logic [SLOTS-1:0]   status,
    output logic               trap
);
    logic [SLOTS-1:0][ADDR_W-1:0] slot_addr;
    logic [SLOTS-1:0]             hit_vec;

    watch_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .task_sw    (task_sw),
        .ctrl_q     (ctrl_word),
        .slot_addr_q(slot_addr)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        watch_slot #(.ADDR_W(ADDR_W)) u_slot (
            .en_pair  (ctrl_word[2*g+1 -: 2]),
            .field    (ctrl_word[FIELD_LSB + FIELD_W*g +: FIELD_W]),
            .slot_addr(slot_addr[g]),
            .acc_valid(acc_valid),
            .acc_addr (acc_addr),
            .acc_kind (acc_kind),
            .wide_en  (wide_en),
            .hit      (hit_vec[g])
        );
    end

    watch_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_vec (hit_vec),
        .stat_clr(stat_clr),
        .status  (status),
        .trap    (trap)
    );

    // R8: any hit raises trap next cycle
    a_r8_trap_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |=> trap);

    // R8: no hit keeps trap low next cycle
    a_r8_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit_vec) |=> !trap);

    // R3: an inactive slot never hits
    a_r3_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[1:0] == 2'b00) |-> !hit_vec[0]);

    // R6: a hit sets its status bit next cycle
    a_r6_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec[0] |=> status[0]);
endmodule

// File: tb/watch_unit_tb.sv
`timescale 1ns/1ps
module watch_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        wide_en = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = 2'd3;
    logic        task_sw = 1'b0;
    logic        stat_clr = 1'b0;
    logic [31:0] ctrl_word;
    logic [3:0]  status;
    logic        trap;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    watch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .wide_en(wide_en), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .task_sw(task_sw),
        .stat_clr(stat_clr), .ctrl_word(ctrl_word), .status(status), .trap(trap)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  kind;
        logic [3:0]  exp;
    } vec_t;

    // kinds: 0 fetch, 1 read, 2 write
    localparam vec_t VECS [12] = '{
        '{32'h0000_1000, 2'd0, 4'b0001},  // R4 fetch slot
        '{32'h0000_1000, 2'd1, 4'b0000},  // R4 read on fetch slot
        '{32'h0000_1001, 2'd0, 4'b0000},  // R5 one byte window
        '{32'h0000_2003, 2'd2, 4'b0010},  // R5 two byte window
        '{32'h0000_2003, 2'd1, 4'b0000},  // R4 write-only slot
        '{32'h0000_2004, 2'd2, 4'b0000},  // R5 outside window
        '{32'h0000_3007, 2'd1, 4'b0100},  // R4 rw slot read
        '{32'h0000_3007, 2'd2, 4'b0100},  // R4 rw slot write
        '{32'h0000_3008, 2'd1, 4'b0000},  // R5 four byte edge
        '{32'h0000_400F, 2'd1, 4'b1000},  // R5 eight byte wide
        '{32'h0000_4010, 2'd2, 4'b0000},  // R5 eight byte edge
        '{32'h0000_3004, 2'd0, 4'b0000}   // R4 fetch on rw slot
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] k, input logic clr);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; stat_clr = clr;
        @(negedge clk);
        acc_valid = 1'b0; acc_kind = 2'd3; stat_clr = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status", {28'd0, status}, 32'd0);
        check("R1 trap", {31'd0, trap}, 32'd0);
        check("R1 ctrl", ctrl_word, 32'd0);
        rst_n = 1'b1;

        wr(3'd0, 32'h0000_1000);
        wr(3'd1, 32'h0000_2002);
        wr(3'd2, 32'h0000_3004);
        wr(3'd3, 32'h0000_4008);
        wr(3'd4, 32'hBF50_FC99);
        check("R2 reserved zero", ctrl_word, 32'hBF50_0099);
        wide_en = 1'b1;

        foreach (VECS[i]) begin
            clear();
            access(VECS[i].addr, VECS[i].kind, 1'b0);
            check($sformatf("R6 vec %0d status", i), {28'd0, status}, {28'd0, VECS[i].exp});
            check($sformatf("R8 vec %0d trap", i), {31'd0, trap}, {31'd0, (VECS[i].exp != 0)});
        end

        // R8: trap falls after an idle cycle
        @(negedge clk);
        check("R8 trap idle", {31'd0, trap}, 32'd0);

        // R5: 8-byte code off without wide mode
        wide_en = 1'b0;
        clear();
        access(32'h0000_400F, 2'd1, 1'b0);
        check("R5 narrow mode", {28'd0, status}, 32'd0);
        wide_en = 1'b1;

        // R6: sticky accumulation
        clear();
        access(32'h0000_1000, 2'd0, 1'b0);
        access(32'h0000_3004, 2'd1, 1'b0);
        @(negedge clk);
        check("R6 sticky", {28'd0, status}, 32'h5);

        // R7: clear together with a hit
        access(32'h0000_2002, 2'd2, 1'b1);
        check("R7 clear with hit", {28'd0, status}, 32'h2);

        // R9: task switch drops local enables
        @(negedge clk);
        task_sw = 1'b1;
        @(negedge clk);
        task_sw = 1'b0;
        check("R9 task switch", ctrl_word, 32'hBF50_0088);
        clear();
        access(32'h0000_1000, 2'd0, 1'b0);
        check("R3 local slot disabled", {28'd0, status}, 32'd0);
        access(32'h0000_2002, 2'd2, 1'b0);
        check("R3 global slot alive", {28'd0, status}, 32'h2);

        // R9: write and task switch in one cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 32'h0000_00FF; task_sw = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; task_sw = 1'b0;
        check("R9 write with switch", ctrl_word, 32'h0000_00AA);

        // R4: I/O type code never matches
        wr(3'd4, 32'h0002_0002);
        clear();
        access(32'h0000_1000, 2'd0, 1'b0);
        access(32'h0000_1000, 2'd1, 1'b0);
        access(32'h0000_1000, 2'd2, 1'b0);
        check("R4 io type", {28'd0, status}, 32'd0);

        // R3: no enable bits, no hit
        wr(3'd4, 32'h0000_0000);
        clear();
        access(32'h0000_1000, 2'd0, 1'b0);
        check("R3 disabled", {28'd0, status}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule